// File: doc/BRIEF.md
# Port-Based Forwarding Table Flush Engine

This block removes the forwarding state that belongs to a chosen set of switch ports. On a start request it captures a port mask and a mode, then visits every row of the address table in ascending order. For each row it reads the row, works out the new content, and writes the row back through a single read-modify-write port into the table RAM. Unicast address rows that point at a flushed port are released. Multicast address rows lose the flushed ports from their membership, and a row is released once its membership is empty.

A mode input picks between a full flush and a multicast-only flush. The multicast-only flush leaves every unicast row and the broadcast row as they are. The engine is used when links go down or when ports leave a group. The surrounding logic pulses start and then waits for the done pulse.

Top module: `port_flush_engine`

## Requirements
- R1: After reset, busy_o, done_o, tbl_rd_o and tbl_wr_o are all 0.
- R2: A start accepted while idle raises busy_o in the next cycle. Each row, in ascending address order from 0, takes three cycles: a read cycle with tbl_rd_o high, a decide cycle, and a write slot. busy_o stays high for exactly 3*DEPTH cycles. done_o pulses for one cycle right after busy_o falls.
- R3: Only rows whose kind field (bits 61:60) is 1 (address) or 3 (address with VLAN) are written back, and each of them is written even when unchanged. Rows of kind 0 or 2 are never written.
- R4: In full mode, a unicast row (bit 40 clear) whose port number in bits 67:66 decodes to a port set in the captured mask gets kind 0. All other bits stay as they were. A port number of 3 or more matches no port.
- R5: A multicast row (bit 40 set) whose membership in bits 68:66 does not intersect the mask is written unchanged. Otherwise the masked bits are cleared in bits 68:66. If nothing remains, the kind becomes 0 and bits 68:66 keep their old value.
- R6: In multicast-only mode (mc_only_i = 1), unicast rows are written back unchanged.
- R7: In multicast-only mode, a row whose address bits 47:0 are all ones is written back unchanged. In full mode, such a row is edited like any other multicast row.
- R8: A zero mask completes the full scan and writes back every considered row unchanged.
- R9: start_i, port_mask_i and mc_only_i are ignored while busy_o is high. The mask and mode captured at the accepted start govern the whole scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| port_mask_i | input | NPORT | Ports to flush, bit n for port n |
| mc_only_i | input | 1 | 1 selects the multicast-only flush |
| busy_o | output | 1 | High while a scan is in progress |
| done_o | output | 1 | One-cycle pulse when the scan completes |
| tbl_addr_o | output | AW | Row address for the table access |
| tbl_rd_o | output | 1 | Read strobe; data is returned one cycle later |
| tbl_rdata_i | input | ROW_W | Read data from the table |
| tbl_wr_o | output | 1 | Write strobe |
| tbl_wdata_o | output | ROW_W | Row content to write |

## Verification
A wrong phase or row counter shows up within one cycle as a strobe or address that differs from the three-cycle-per-row schedule. It also moves the fall of busy and the done pulse. A wrong captured mask, a wrong mode or a wrong edit decision shows up in the write slot of the affected row as a write data word that differs from the expected row. A write to a skipped row, or a missing write to a considered row, is visible in that same slot. The bench also compares the whole table after each scan, so any error in table content is caught at the latest when the scan ends.

// File: rtl/fe_pkg.sv
package fe_pkg;

   typedef enum logic [1:0] {
      KIND_FREE      = 2'd0,
      KIND_ADDR      = 2'd1,
      KIND_VLAN      = 2'd2,
      KIND_VLAN_ADDR = 2'd3
   } row_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_READ,
      PH_DECIDE,
      PH_WRITE
   } phase_e;

   // Field positions that the table and its other users decode.
   localparam int KIND_LSB = 60;
   localparam int MC_BIT   = 40;
   localparam int MAC_W    = 48;
   localparam int PORT_LSB = 66;

endpackage

// File: rtl/fe_walker.sv
module fe_walker #(
   parameter int DEPTH = 16,
   parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   output logic          accept_o,
   output logic          rd_o,
   output logic          dec_o,
   output logic          wr_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [AW-1:0] row_o
);
   import fe_pkg::*;

   localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("fe_walker: DEPTH must be at least 1");
   end
   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("fe_walker: AW too narrow for DEPTH");
   end

   phase_e        ph_q;
   logic [AW-1:0] row_q;
   logic          done_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         row_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (ph_q == PH_WRITE) && (row_q == LAST_ROW);
         case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  ph_q  <= PH_READ;
                  row_q <= '0;
               end
            end
            PH_READ:   ph_q <= PH_DECIDE;
            PH_DECIDE: ph_q <= PH_WRITE;
            PH_WRITE: begin
               if (row_q == LAST_ROW) begin
                  ph_q <= PH_IDLE;
               end else begin
                  ph_q  <= PH_READ;
                  row_q <= row_q + AW'(1);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign accept_o = (ph_q == PH_IDLE) && start_i;
   assign rd_o     = (ph_q == PH_READ);
   assign dec_o    = (ph_q == PH_DECIDE);
   assign wr_o     = (ph_q == PH_WRITE);
   assign busy_o   = (ph_q != PH_IDLE);
   assign done_o   = done_q;
   assign row_o    = row_q;

endmodule

// File: rtl/fe_row_edit.sv
module fe_row_edit #(
   parameter int ROW_W = 72,
   parameter int NPORT = 3
) (
   input  logic [ROW_W-1:0] row_i,
   input  logic [NPORT-1:0] mask_i,
   input  logic             mc_only_i,
   output logic             take_o,
   output logic [ROW_W-1:0] row_o
);
   import fe_pkg::*;

   localparam int PN_W = (NPORT > 1) ? $clog2(NPORT) : 1;

   if (PORT_LSB + NPORT > ROW_W) begin : g_bad_row
      $error("fe_row_edit: membership field exceeds ROW_W");
   end
   if (PN_W > NPORT) begin : g_bad_pn
      $error("fe_row_edit: port number wider than membership field");
   end

   row_kind_e        kind;
   logic             is_mc;
   logic             is_bc;
   logic [NPORT-1:0] members;
   logic [NPORT-1:0] remain;
   logic [PN_W-1:0]  port_num;
   logic [NPORT-1:0] port_hot;
   logic             hit_mc;
   logic             hit_uc;

   assign kind     = row_kind_e'(row_i[KIND_LSB +: 2]);
   assign is_mc    = row_i[MC_BIT];
   assign is_bc    = &row_i[MAC_W-1:0];
   assign members  = row_i[PORT_LSB +: NPORT];
   assign port_num = row_i[PORT_LSB +: PN_W];
   assign remain   = members & ~mask_i;
   assign hit_mc   = |(members & mask_i);

   // One-hot decode of the unicast port number; out-of-range values give zero.
   for (genvar p = 0; p < NPORT; p++) begin : g_dec
      assign port_hot[p] = (port_num == PN_W'(p));
   end

   assign hit_uc = |(port_hot & mask_i);
   assign take_o = (kind == KIND_ADDR) || (kind == KIND_VLAN_ADDR);

   always_comb begin
      row_o = row_i;
      if (is_mc) begin
         if (!(mc_only_i && is_bc) && hit_mc) begin
            if (remain == '0) begin
               row_o[KIND_LSB +: 2] = KIND_FREE;
            end else begin
               row_o[PORT_LSB +: NPORT] = remain;
            end
         end
      end else if (!mc_only_i && hit_uc) begin
         row_o[KIND_LSB +: 2] = KIND_FREE;
      end
   end

endmodule

// File: rtl/port_flush_engine.sv
module port_flush_engine #(
   parameter int DEPTH = 16,
   parameter int NPORT = 3,
   parameter int ROW_W = 72,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [NPORT-1:0] port_mask_i,
   input  logic             mc_only_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [AW-1:0]    tbl_addr_o,
   output logic             tbl_rd_o,
   input  logic [ROW_W-1:0] tbl_rdata_i,
   output logic             tbl_wr_o,
   output logic [ROW_W-1:0] tbl_wdata_o
);
   import fe_pkg::*;

   if (NPORT < 2) begin : g_bad_nport
      $error("port_flush_engine: NPORT must be at least 2");
   end
   if (ROW_W < KIND_LSB + 2) begin : g_bad_width
      $error("port_flush_engine: ROW_W too small for kind field");
   end

   logic             accept;
   logic             ph_rd;
   logic             ph_dec;
   logic             ph_wr;
   logic [NPORT-1:0] mask_q;
   logic             mc_only_q;
   logic             take_d;
   logic             take_q;
   logic [ROW_W-1:0] edit_d;
   logic [ROW_W-1:0] edit_q;

   fe_walker #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_walk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .accept_o (accept),
      .rd_o     (ph_rd),
      .dec_o    (ph_dec),
      .wr_o     (ph_wr),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .row_o    (tbl_addr_o)
   );

   fe_row_edit #(
      .ROW_W (ROW_W),
      .NPORT (NPORT)
   ) u_edit (
      .row_i     (tbl_rdata_i),
      .mask_i    (mask_q),
      .mc_only_i (mc_only_q),
      .take_o    (take_d),
      .row_o     (edit_d)
   );

   // Mask and mode are frozen for the whole scan.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mask_q    <= '0;
         mc_only_q <= 1'b0;
      end else if (accept) begin
         mask_q    <= port_mask_i;
         mc_only_q <= mc_only_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         take_q <= 1'b0;
         edit_q <= '0;
      end else if (ph_dec) begin
         take_q <= take_d;
         edit_q <= edit_d;
      end
   end

   assign tbl_rd_o    = ph_rd;
   assign tbl_wr_o    = ph_wr && take_q;
   assign tbl_wdata_o = edit_q;

endmodule

// File: rtl/fe_flush_chk.sv
module fe_flush_chk #(
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          tbl_rd_o,
   input logic          tbl_wr_o,
   input logic [AW-1:0] tbl_addr_o,
   input logic [1:0]    rd_kind,
   input logic [47:0]   rd_mac,
   input logic [47:0]   wr_mac
);

   AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tbl_rd_o && tbl_wr_o)); // R2

   AST_WR_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_wr_o |-> busy_o); // R2

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && $past(busy_o))); // R2

   AST_RD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_rd_o |=> (!tbl_rd_o && !tbl_wr_o)); // R2

   AST_WR_SAME_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_wr_o |-> ($past(tbl_rd_o, 2) && tbl_addr_o == $past(tbl_addr_o, 2))); // R2

   AST_WR_KIND_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_wr_o |-> ($past(rd_kind) == 2'd1 || $past(rd_kind) == 2'd3)); // R3

   AST_MAC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_wr_o |-> (wr_mac == $past(rd_mac))); // R4

   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i && !tbl_wr_o) |=> busy_o); // R9

endmodule

bind port_flush_engine fe_flush_chk #(
   .DEPTH (DEPTH)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .tbl_rd_o   (tbl_rd_o),
   .tbl_wr_o   (tbl_wr_o),
   .tbl_addr_o (tbl_addr_o),
   .rd_kind    (tbl_rdata_i[fe_pkg::KIND_LSB +: 2]),
   .rd_mac     (tbl_rdata_i[fe_pkg::MAC_W-1:0]),
   .wr_mac     (tbl_wdata_o[fe_pkg::MAC_W-1:0])
);

// File: tb/port_flush_engine_tb_top.sv
module port_flush_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int NPORT = 3;
   localparam int ROW_W = 72;
   localparam int AW    = 4;

   localparam logic [47:0] UC_MAC = 48'h0200_0000_0011;
   localparam logic [47:0] MC_MAC = 48'h0100_5e00_0001;
   localparam logic [47:0] BC_MAC = 48'hFFFF_FFFF_FFFF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [NPORT-1:0] pmask = '0;
   logic             mc_only = 1'b0;
   logic             busy;
   logic             done;
   logic [AW-1:0]    taddr;
   logic             trd;
   logic [ROW_W-1:0] trdata = '0;
   logic             twr;
   logic [ROW_W-1:0] twdata;

   logic [ROW_W-1:0] mem [DEPTH];
   logic [ROW_W-1:0] exp_final [DEPTH];
   bit               exp_take [DEPTH];

   int  n_chk = 0;
   int  n_fail = 0;
   bit  m_busy = 0;
   bit  m_done = 0;
   int  m_cnt = 0;
   bit  live = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   port_flush_engine #(.DEPTH(DEPTH), .NPORT(NPORT), .ROW_W(ROW_W)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .port_mask_i (pmask),
      .mc_only_i   (mc_only),
      .busy_o      (busy),
      .done_o      (done),
      .tbl_addr_o  (taddr),
      .tbl_rd_o    (trd),
      .tbl_rdata_i (trdata),
      .tbl_wr_o    (twr),
      .tbl_wdata_o (twdata)
   );

   // Table RAM: synchronous read, one cycle of latency.
   always @(posedge clk) begin
      if (trd) trdata <= mem[taddr];
      if (twr) mem[taddr] <= twdata;
   end

   function automatic logic [ROW_W-1:0] mk(input int kind, input logic [47:0] mac,
                                           input int field, input int vid);
      logic [ROW_W-1:0] r;
      r = '0;
      r[47:0]  = mac;
      r[59:48] = vid[11:0];
      r[61:60] = kind[1:0];
      r[68:66] = field[2:0];
      r[71:69] = 3'b101;
      return r;
   endfunction

   function automatic bit ref_take(input logic [ROW_W-1:0] r);
      return (r[61:60] == 2'd1) || (r[61:60] == 2'd3);
   endfunction

   function automatic logic [ROW_W-1:0] ref_edit(input logic [ROW_W-1:0] r,
                                                 input logic [2:0] m, input bit mco);
      logic [ROW_W-1:0] o;
      logic [2:0] grp;
      int pn;
      o = r;
      if (r[40]) begin
         if (mco && r[47:0] == BC_MAC) return o;
         grp = r[68:66];
         if ((grp & m) == 3'b000) return o;
         grp = grp & ~m;
         if (grp == 3'b000) o[61:60] = 2'd0;
         else o[68:66] = grp;
      end else begin
         if (mco) return o;
         pn = int'(r[67:66]);
         if (pn < NPORT && m[pn]) o[61:60] = 2'd0;
      end
      return o;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [ROW_W-1:0] act,
                      input logic [ROW_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference of the scan schedule.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0;
      end else if (m_busy) begin
         if (m_cnt == 3*DEPTH - 1) begin
            m_busy = 0; m_done = 1;
         end else begin
            m_cnt++;
         end
      end else begin
         m_done = 0;
         if (start) begin
            m_busy = 1; m_cnt = 0;
            for (int i = 0; i < DEPTH; i++) begin
               exp_take[i]  = ref_take(mem[i]);
               exp_final[i] = exp_take[i] ? ref_edit(mem[i], pmask, mc_only) : mem[i];
            end
         end
      end
   end

   // Compare against the reference on every clock (R2, R3, R4).
   always @(negedge clk) begin
      if (live) begin
         bit e_rd, e_wr;
         int row;
         row  = m_cnt / 3;
         e_rd = m_busy && (m_cnt % 3 == 0);
         e_wr = m_busy && (m_cnt % 3 == 2) && exp_take[row];
         chk(busy == m_busy, "R2 busy", ROW_W'(busy), ROW_W'(m_busy));
         chk(done == m_done, "R2 done", ROW_W'(done), ROW_W'(m_done));
         chk(trd == e_rd, "R2 read strobe", ROW_W'(trd), ROW_W'(e_rd));
         chk(twr == e_wr, "R3 write strobe", ROW_W'(twr), ROW_W'(e_wr));
         if (e_rd || e_wr)
            chk(taddr == AW'(row), "R2 address", ROW_W'(taddr), ROW_W'(row));
         if (e_wr)
            chk(twdata == exp_final[row], "R4 write data", twdata, exp_final[row]);
      end
   end

   task automatic load_table();
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      mem[0] = mk(1, UC_MAC, 1, 0);       // unicast port 1
      mem[1] = mk(1, UC_MAC + 1, 0, 0);   // unicast port 0
      mem[2] = mk(1, UC_MAC + 2, 3, 0);   // unicast, port number out of range
      mem[3] = mk(1, MC_MAC, 6, 0);       // group {1,2}
      mem[4] = mk(1, MC_MAC + 1, 2, 0);   // group {1}
      mem[5] = mk(1, MC_MAC + 2, 1, 0);   // group {0}
      mem[6] = mk(0, UC_MAC + 3, 1, 0);   // free kind
      mem[7] = mk(2, MC_MAC + 3, 2, 5);   // vlan kind
      mem[8] = mk(1, BC_MAC, 3, 0);       // broadcast, group {0,1}
      mem[9] = mk(3, UC_MAC + 4, 1, 'h123); // vlan address, unicast port 1
   endtask

   task automatic run_scan(input logic [2:0] m, input bit mco, input bit poke);
      @(negedge clk);
      start = 1'b1; pmask = m; mc_only = mco;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (10) @(negedge clk);
         start = 1'b1; pmask = ~m; mc_only = ~mco;
         repeat (2) @(negedge clk);
         start = 1'b0;
      end
      while (!(m_done && !m_busy)) @(negedge clk);
      @(negedge clk);
      pmask = '0; mc_only = 1'b0;
   endtask

   task automatic chk_row(input int i, input string tag);
      chk(mem[i] === exp_final[i], tag, mem[i], exp_final[i]);
   endtask

   logic [ROW_W-1:0] orig [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!busy && !done && !trd && !twr, "R1 reset state",
          ROW_W'({busy, done, trd, twr}), '0);
      @(negedge clk);
      live = 1;

      // Full flush of port 1.
      load_table();
      run_scan(3'b010, 1'b0, 1'b0);
      chk_row(0, "R4 unicast port hit");
      chk_row(1, "R4 unicast port miss");
      chk_row(2, "R4 out of range port");
      chk_row(9, "R4 vlan address unicast");
      chk_row(3, "R5 membership trimmed");
      chk_row(4, "R5 membership emptied");
      chk_row(5, "R5 no intersection");
      chk_row(6, "R3 free kind untouched");
      chk_row(7, "R3 vlan kind untouched");
      chk_row(8, "R7 broadcast edited in full mode");
      chk(mem[0][61:60] == 2'd0, "R4 freed kind", ROW_W'(mem[0][61:60]), '0);

      // Multicast-only flush of ports 0 and 1.
      load_table();
      for (int i = 0; i < DEPTH; i++) orig[i] = mem[i];
      run_scan(3'b011, 1'b1, 1'b0);
      chk_row(0, "R6 unicast spared");
      chk_row(1, "R6 unicast spared");
      chk_row(9, "R6 unicast spared");
      chk(mem[0] === orig[0], "R6 unicast unchanged", mem[0], orig[0]);
      chk_row(8, "R7 broadcast spared");
      chk(mem[8] === orig[8], "R7 broadcast unchanged", mem[8], orig[8]);
      chk_row(3, "R5 trimmed");
      chk_row(4, "R5 freed");
      chk_row(5, "R5 freed");

      // Zero mask.
      load_table();
      for (int i = 0; i < DEPTH; i++) orig[i] = mem[i];
      run_scan(3'b000, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++)
         chk(mem[i] === orig[i], "R8 zero mask", mem[i], orig[i]);

      // Start while busy with other mask and mode.
      load_table();
      run_scan(3'b001, 1'b0, 1'b1);
      for (int i = 0; i < DEPTH; i++) chk_row(i, "R9 captured mask kept");
      chk(mem[1][61:60] == 2'd0, "R9 port 0 unicast freed", ROW_W'(mem[1][61:60]), '0);
      chk(mem[3] === orig[3], "R9 group without port 0 kept", mem[3], orig[3]);

      // Every port.
      load_table();
      run_scan(3'b111, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) chk_row(i, "R4 all ports");

      live = 0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule